// File: doc/BRIEF.md
# History-Tracked Boot Image Selector

After a bootstrap configuration has loaded, this block decides which of up to `NUM_IMG` application images the device should launch next. It reads a short header for each image. From that header it takes a 16-bit state word and a 16-bit revision word. Images whose state word does not mark them as valid are discarded, and the block prefers the newest revision among the rest. Every launch is logged in a history page of flash before the reboot request goes out. A later bootstrap run can then see that an image failed to come up, retry it, or give up on it.

Flash can only clear bits, so retries are counted by clearing further bits of one history byte. Each new candidate gets a fresh byte, and a byte never has to return from 0 to 1. When the page is used up it is erased. In application mode the block makes no selection. It only clears the live history byte to confirm that the load succeeded.

All flash access goes through a one-request-at-a-time byte port that offers read, write (bitwise AND) and page erase. Each request is held until it is acknowledged.

Top module: `boot_chooser`

## Requirements
- R1: Only an image whose header state word (bytes 0 and 1 at its base, high byte first) equals 0x00FF is a candidate. 0xFFFF (empty) and 0x0000 (invalidated) images are never launched.
- R2: Among candidates, the one with the largest revision word (header bytes 2 and 3, high byte first) is launched. On equal revisions, the lower image number wins.
- R3: A launch writes the image number (1..NUM_IMG) to the upper nibble of the history byte. The lower nibble is 0xE on the first attempt, 0xC on the second and 0x8 on the third. A repeat attempt rewrites the same byte.
- R4: If the live history byte already records a third attempt, the next bootstrap run does four things. It writes that byte to 0x00, writes the image's state word to 0x0000, launches the best remaining candidate and records it in the following byte.
- R5: The live history byte is the first non-zero byte of the page. The value 0xFF there means there is no history and a fresh selection is made.
- R6: In application mode the live history byte is written to 0x00 if it is not 0xFF. No reboot is issued and no header is touched.
- R7: When a scan finds all PAGE_BYTES bytes at 0x00, the page is erased. The same happens when a retired byte is the last one in the page. The next entry then goes to byte 0.
- R8: `prog_n` goes low for exactly one cycle for each image invalidated, whether after three attempts or after a CRC error.
- R9: The history write is acknowledged before `reboot` pulses. `reboot` lasts one cycle and `reboot_addr` carries the chosen image's base address, zero-extended to 32 bits.
- R10: If a `crc_err` bit is set at `start` for an image with a valid header, that image is invalidated and excluded from the selection.
- R11: If no candidate remains, `no_image` goes high and stays high until the next `start`. No reboot is issued and no new history entry is written.
- R12: Once raised, `fl_req` stays high with a stable opcode and address until `fl_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run |
| app_mode | input | 1 | Sampled at start: 1 confirms the current load, 0 selects an image |
| crc_err | input | NUM_IMG | Sampled at start: per-image CRC mismatch flags |
| fl_req | output | 1 | Flash request valid |
| fl_op | output | 2 | 0 read, 1 write (AND), 2 page erase |
| fl_addr | output | ADDR_W | Byte address (page base for an erase) |
| fl_wdata | output | 8 | Write data |
| fl_ack | input | 1 | Request completed; read data valid in the same cycle |
| fl_rdata | input | 8 | Read data |
| reboot | output | 1 | One-cycle reboot request |
| reboot_addr | output | 32 | Start address of the chosen image |
| prog_n | output | 1 | Active-low pulse per invalidated image |
| no_image | output | 1 | No launchable image was found |
| busy | output | 1 | A run is in progress |
| run_done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The assertions assume the flash side answers every request with exactly one `fl_ack` and delivers read data in that same cycle. They also assume `start` arrives only while `busy` is low. The bench model acknowledges one cycle after it sees a request and never acknowledges an idle port. Every run is started from the idle state and waits for `run_done` before the next one. History contents are always preloaded in a form the block can produce: zero bytes, then one live byte carrying a legal image number and attempt code.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;
  localparam logic [1:0]  FOP_RD = 2'd0;
  localparam logic [1:0]  FOP_WR = 2'd1;
  localparam logic [1:0]  FOP_ER = 2'd2;
  localparam logic [3:0]  TRY_1ST = 4'hE;
  localparam logic [3:0]  TRY_2ND = 4'hC;
  localparam logic [3:0]  TRY_3RD = 4'h8;
  localparam logic [15:0] HDR_OK  = 16'h00FF;
  localparam logic [7:0]  HIST_NONE = 8'hFF;

  typedef enum logic [1:0] {ACT_FRESH, ACT_RETRY, ACT_GIVE_UP} hist_act_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SCAN, ST_WIPE, ST_HDR, ST_DECIDE, ST_RETIRE, ST_ADV,
    ST_KILL, ST_PICK, ST_REC, ST_BOOT, ST_CLEAR, ST_DONE
  } sel_state_e;
endpackage

// File: rtl/rev_rank.sv
module rev_rank
  import boot_sel_pkg::*;
#(
  parameter int N     = 3,
  parameter int IDX_W = 2
)(
  input  logic [N-1:0]    alive,
  input  logic [N*16-1:0] revs,
  output logic            found,
  output logic [IDX_W-1:0] best
);
  logic [15:0] best_rev;

  // strict compare: lower index keeps a tie
  always_comb begin
    found    = 1'b0;
    best     = '0;
    best_rev = '0;
    for (int i = 0; i < N; i++) begin
      if (alive[i] && (!found || revs[i*16 +: 16] > best_rev)) begin
        found    = 1'b1;
        best     = IDX_W'(i);
        best_rev = revs[i*16 +: 16];
      end
    end
  end
endmodule

// File: rtl/hist_step.sv
module hist_step
  import boot_sel_pkg::*;
#(
  parameter int N     = 3,
  parameter int IDX_W = 2
)(
  input  logic [7:0]       hbyte,
  input  logic [N-1:0]     alive,
  output hist_act_e        act,
  output logic [7:0]       next_code,
  output logic [IDX_W-1:0] cur_idx,
  output logic             cur_known
);
  logic [3:0] img_no;
  logic [3:0] tries;
  logic       cur_alive;

  always_comb begin
    img_no    = hbyte[7:4];
    tries     = hbyte[3:0];
    cur_known = (img_no != 4'd0) && (int'(img_no) <= N);
    cur_idx   = cur_known ? IDX_W'(img_no - 4'd1) : '0;
    cur_alive = cur_known && alive[cur_idx];
    next_code = hbyte;
    if (hbyte == HIST_NONE) begin
      act = ACT_FRESH;
    end else if (cur_alive && tries == TRY_1ST) begin
      act       = ACT_RETRY;
      next_code = {img_no, TRY_2ND};
    end else if (cur_alive && tries == TRY_2ND) begin
      act       = ACT_RETRY;
      next_code = {img_no, TRY_3RD};
    end else begin
      act = ACT_GIVE_UP;
    end
  end
endmodule

// File: rtl/boot_chooser.sv
module boot_chooser
  import boot_sel_pkg::*;
#(
  parameter int NUM_IMG    = 3,
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256,
  parameter logic [ADDR_W-1:0]         HIST_BASE = 24'h070000,
  parameter logic [NUM_IMG*ADDR_W-1:0] IMG_BASES = {24'h180000, 24'h100000, 24'h080000}
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               app_mode,
  input  logic [NUM_IMG-1:0] crc_err,
  output logic               fl_req,
  output logic [1:0]         fl_op,
  output logic [ADDR_W-1:0]  fl_addr,
  output logic [7:0]         fl_wdata,
  input  logic               fl_ack,
  input  logic [7:0]         fl_rdata,
  output logic               reboot,
  output logic [31:0]        reboot_addr,
  output logic               prog_n,
  output logic               no_image,
  output logic               busy,
  output logic               run_done
);
  localparam int PTR_W = $clog2(PAGE_BYTES);
  localparam int IDX_W = (NUM_IMG > 1) ? $clog2(NUM_IMG) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(PAGE_BYTES - 1);
  localparam logic [IDX_W-1:0] LAST_IMG = IDX_W'(NUM_IMG - 1);

  sel_state_e           state_q, state_d;
  logic [PTR_W-1:0]     ptr_q, ptr_d;
  logic [7:0]           hval_q, hval_d;
  logic [IDX_W-1:0]     img_q, img_d;
  logic [1:0]           bj_q, bj_d;
  logic [NUM_IMG*16-1:0] st_q, st_d, rev_q, rev_d;
  logic [NUM_IMG-1:0]   alive_q, alive_d, kill_q, kill_d, crc_q, crc_d;
  logic                 again_q, again_d;
  logic [IDX_W-1:0]     pick_q, pick_d;
  logic [7:0]           wcode_q, wcode_d;
  logic                 prog_q, prog_d;
  logic                 noimg_q, noimg_d;
  logic                 mode_q, mode_d;

  logic [NUM_IMG-1:0]   hdr_ok;
  logic [IDX_W-1:0]     kidx;
  logic                 rank_found;
  logic [IDX_W-1:0]     rank_best;
  hist_act_e            h_act;
  logic [7:0]           h_next;
  logic [IDX_W-1:0]     h_idx;
  logic                 h_known;

  function automatic logic [ADDR_W-1:0] img_base(input logic [IDX_W-1:0] i);
    return IMG_BASES[int'(i)*ADDR_W +: ADDR_W];
  endfunction

  for (genvar g = 0; g < NUM_IMG; g++) begin : g_hdr
    assign hdr_ok[g] = (st_q[g*16 +: 16] == HDR_OK);
  end

  rev_rank #(.N(NUM_IMG), .IDX_W(IDX_W)) u_rank (
    .alive (alive_q),
    .revs  (rev_q),
    .found (rank_found),
    .best  (rank_best)
  );

  hist_step #(.N(NUM_IMG), .IDX_W(IDX_W)) u_step (
    .hbyte     (hval_q),
    .alive     (hdr_ok & ~crc_q),
    .act       (h_act),
    .next_code (h_next),
    .cur_idx   (h_idx),
    .cur_known (h_known)
  );

  always_comb begin
    kidx = '0;
    for (int i = NUM_IMG - 1; i >= 0; i--) begin
      if (kill_q[i]) kidx = IDX_W'(i);
    end
  end

  // flash port, decoded from state
  always_comb begin
    fl_req   = 1'b0;
    fl_op    = FOP_WR;
    fl_addr  = HIST_BASE + ADDR_W'(ptr_q);
    fl_wdata = 8'h00;
    unique case (state_q)
      ST_SCAN:   begin fl_req = 1'b1; fl_op = FOP_RD; end
      ST_WIPE:   begin fl_req = 1'b1; fl_op = FOP_ER; fl_addr = HIST_BASE; end
      ST_HDR:    begin fl_req = 1'b1; fl_op = FOP_RD; fl_addr = img_base(img_q) + ADDR_W'(bj_q); end
      ST_RETIRE: fl_req = 1'b1;
      ST_ADV:    begin fl_req = (ptr_q == LAST_PTR); fl_op = FOP_ER; fl_addr = HIST_BASE; end
      ST_KILL:   begin fl_req = (kill_q != '0); fl_addr = img_base(kidx) + ADDR_W'(bj_q); end
      ST_REC:    begin fl_req = 1'b1; fl_wdata = wcode_q; end
      ST_CLEAR:  fl_req = 1'b1;
      default:   ;
    endcase
  end

  // next-state
  always_comb begin
    state_d = state_q;  ptr_d  = ptr_q;   hval_d  = hval_q;  img_d   = img_q;
    bj_d    = bj_q;     st_d   = st_q;    rev_d   = rev_q;   alive_d = alive_q;
    kill_d  = kill_q;   crc_d  = crc_q;   again_d = again_q; pick_d  = pick_q;
    wcode_d = wcode_q;  noimg_d = noimg_q; mode_d = mode_q;
    prog_d  = 1'b1;
    unique case (state_q)
      ST_IDLE: if (start) begin
        ptr_d = '0; img_d = '0; bj_d = '0; noimg_d = 1'b0;
        mode_d = app_mode; crc_d = crc_err;
        state_d = ST_SCAN;
      end
      ST_SCAN: if (fl_ack) begin
        if (fl_rdata != 8'h00) begin
          hval_d = fl_rdata;
          if (!mode_q)                     state_d = ST_HDR;
          else if (fl_rdata == HIST_NONE)  state_d = ST_DONE;
          else                             state_d = ST_CLEAR;
        end else if (ptr_q == LAST_PTR) begin
          state_d = ST_WIPE;
        end else begin
          ptr_d = ptr_q + 1'b1;
        end
      end
      ST_WIPE: if (fl_ack) begin
        ptr_d = '0; hval_d = HIST_NONE;
        state_d = mode_q ? ST_DONE : ST_HDR;
      end
      ST_HDR: if (fl_ack) begin
        unique case (bj_q)
          2'd0: st_d[int'(img_q)*16 + 8 +: 8]  = fl_rdata;
          2'd1: st_d[int'(img_q)*16 +: 8]      = fl_rdata;
          2'd2: rev_d[int'(img_q)*16 + 8 +: 8] = fl_rdata;
          default: rev_d[int'(img_q)*16 +: 8]  = fl_rdata;
        endcase
        bj_d = bj_q + 2'd1;
        if (bj_q == 2'd3) begin
          if (img_q == LAST_IMG) state_d = ST_DECIDE;
          else                   img_d = img_q + 1'b1;
        end
      end
      ST_DECIDE: begin
        alive_d = hdr_ok & ~crc_q;
        kill_d  = hdr_ok & crc_q;
        again_d = 1'b0;
        bj_d    = '0;
        unique case (h_act)
          ACT_RETRY: begin
            again_d = 1'b1; pick_d = h_idx; wcode_d = h_next;
            state_d = ST_KILL;
          end
          ACT_GIVE_UP: begin
            if (h_known) begin
              alive_d[h_idx] = 1'b0;
              kill_d[h_idx]  = hdr_ok[h_idx];
            end
            state_d = ST_RETIRE;
          end
          default: state_d = ST_KILL;
        endcase
      end
      ST_RETIRE: if (fl_ack) state_d = ST_ADV;
      ST_ADV: begin
        if (ptr_q != LAST_PTR) begin
          ptr_d = ptr_q + 1'b1; state_d = ST_KILL;
        end else if (fl_ack) begin
          ptr_d = '0; state_d = ST_KILL;
        end
      end
      ST_KILL: begin
        if (kill_q == '0) begin
          state_d = again_q ? ST_REC : ST_PICK;
        end else if (fl_ack) begin
          if (bj_q == 2'd1) begin
            bj_d = '0; kill_d[kidx] = 1'b0; prog_d = 1'b0;
          end else begin
            bj_d = 2'd1;
          end
        end
      end
      ST_PICK: begin
        if (!rank_found) begin
          noimg_d = 1'b1; state_d = ST_DONE;
        end else begin
          pick_d  = rank_best;
          wcode_d = {4'(rank_best) + 4'd1, TRY_1ST};
          state_d = ST_REC;
        end
      end
      ST_REC:   if (fl_ack) state_d = ST_BOOT;
      ST_BOOT:  state_d = ST_DONE;
      ST_CLEAR: if (fl_ack) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; ptr_q <= '0; hval_q <= HIST_NONE; img_q <= '0;
      bj_q <= '0; st_q <= '0; rev_q <= '0; alive_q <= '0; kill_q <= '0;
      crc_q <= '0; again_q <= 1'b0; pick_q <= '0; wcode_q <= HIST_NONE;
      prog_q <= 1'b1; noimg_q <= 1'b0; mode_q <= 1'b0;
    end else begin
      state_q <= state_d; ptr_q <= ptr_d; hval_q <= hval_d; img_q <= img_d;
      bj_q <= bj_d; st_q <= st_d; rev_q <= rev_d; alive_q <= alive_d;
      kill_q <= kill_d; crc_q <= crc_d; again_q <= again_d; pick_q <= pick_d;
      wcode_q <= wcode_d; prog_q <= prog_d; noimg_q <= noimg_d; mode_q <= mode_d;
    end
  end

  assign reboot      = (state_q == ST_BOOT);
  assign reboot_addr = 32'(img_base(pick_q));
  assign prog_n      = prog_q;
  assign no_image    = noimg_q;
  assign busy        = (state_q != ST_IDLE);
  assign run_done    = (state_q == ST_DONE);

  // R3
  rec_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REC) |-> (fl_wdata[7:4] != 4'd0 && int'(fl_wdata[7:4]) <= NUM_IMG &&
      (fl_wdata[3:0] == TRY_1ST || fl_wdata[3:0] == TRY_2ND || fl_wdata[3:0] == TRY_3RD)));
  // R6
  app_no_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reboot |-> !mode_q);
  // R8
  prog_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> $past(fl_req && fl_ack && fl_op == FOP_WR && fl_wdata == 8'h00));
  // R9
  rec_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reboot |-> $past(fl_req && fl_ack && fl_op == FOP_WR && fl_wdata != 8'h00));
  // R9
  boot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reboot |=> !reboot);
  // R11
  none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_image |-> !reboot);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && !fl_ack) |=> (fl_req && $stable(fl_addr) && $stable(fl_op)));
endmodule

// File: tb/sim_boot_chooser.sv
module sim_boot_chooser;
  localparam logic [23:0] HB = 24'h070000;
  localparam logic [23:0] B1 = 24'h080000;
  localparam logic [23:0] B2 = 24'h100000;
  localparam logic [23:0] B3 = 24'h180000;

  logic clk = 1'b0;
  logic rst_n, start, app_mode;
  logic [2:0]  crc_err;
  logic        fl_req, fl_ack, reboot, prog_n, no_image, busy, run_done;
  logic [1:0]  fl_op;
  logic [23:0] fl_addr;
  logic [7:0]  fl_wdata, fl_rdata;
  logic [31:0] reboot_addr;

  always #5 clk = ~clk;

  boot_chooser u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .app_mode(app_mode), .crc_err(crc_err),
    .fl_req(fl_req), .fl_op(fl_op), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_ack(fl_ack), .fl_rdata(fl_rdata), .reboot(reboot), .reboot_addr(reboot_addr),
    .prog_n(prog_n), .no_image(no_image), .busy(busy), .run_done(run_done)
  );

  // flash model: history page + 3 four-byte headers, loaded via ld_* port
  logic [7:0] hist [256];
  logic [7:0] hdr  [3][4];
  logic       ld_en, ld_hdr;
  logic [7:0] ld_idx, ld_data;

  function automatic logic [7:0] rd_mem(input logic [23:0] a);
    if (a[23:8] == HB[23:8]) return hist[a[7:0]];
    if (a[23:2] == B1[23:2]) return hdr[0][a[1:0]];
    if (a[23:2] == B2[23:2]) return hdr[1][a[1:0]];
    if (a[23:2] == B3[23:2]) return hdr[2][a[1:0]];
    return 8'hFF;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_ack <= 1'b0; fl_rdata <= 8'h00;
    end else begin
      if (ld_en) begin
        if (ld_hdr) hdr[ld_idx[3:2]][ld_idx[1:0]] <= ld_data;
        else        hist[ld_idx] <= ld_data;
      end
      if (fl_req && !fl_ack) begin
        fl_ack <= 1'b1;
        fl_rdata <= rd_mem(fl_addr);
        if (fl_op == 2'd1) begin
          if (fl_addr[23:8] == HB[23:8]) hist[fl_addr[7:0]] <= hist[fl_addr[7:0]] & fl_wdata;
          else if (fl_addr[23:2] == B1[23:2]) hdr[0][fl_addr[1:0]] <= hdr[0][fl_addr[1:0]] & fl_wdata;
          else if (fl_addr[23:2] == B2[23:2]) hdr[1][fl_addr[1:0]] <= hdr[1][fl_addr[1:0]] & fl_wdata;
          else if (fl_addr[23:2] == B3[23:2]) hdr[2][fl_addr[1:0]] <= hdr[2][fl_addr[1:0]] & fl_wdata;
        end else if (fl_op == 2'd2 && fl_addr == HB) begin
          for (int i = 0; i < 256; i++) hist[i] <= 8'hFF;
        end
      end else begin
        fl_ack <= 1'b0;
      end
    end
  end

  // monitor
  int boot_cnt = 0, prog_cnt = 0, hold_err = 0, cyc = 0;
  logic [31:0] boot_addr_seen;
  logic [7:0]  snap [256];
  logic        req_p, ack_p;
  logic [23:0] addr_p;
  always @(posedge clk) begin
    if (rst_n) begin
      if (reboot) begin boot_cnt++; boot_addr_seen <= reboot_addr; snap <= hist; end
      if (!prog_n) prog_cnt++;
      if (req_p && !ack_p && (!fl_req || fl_addr != addr_p)) hold_err++;
    end
    req_p <= rst_n && fl_req; ack_p <= fl_ack; addr_p <= fl_addr;
  end

  int n_chk = 0, n_fail = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input bit is_hdr, input logic [7:0] idx, input logic [7:0] d);
    ld_en = 1'b1; ld_hdr = is_hdr; ld_idx = idx; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic set_hdr(input int img, input logic [15:0] st, input logic [15:0] rv);
    poke(1, 8'(img*4 + 0), st[15:8]);
    poke(1, 8'(img*4 + 1), st[7:0]);
    poke(1, 8'(img*4 + 2), rv[15:8]);
    poke(1, 8'(img*4 + 3), rv[7:0]);
  endtask

  task automatic fill_hist(input logic [7:0] v);
    for (int i = 0; i < 256; i++) poke(0, 8'(i), v);
  endtask

  int d_boot, d_prog;
  task automatic run(input bit app, input logic [2:0] crc);
    int b0, p0;
    bit seen;
    b0 = boot_cnt; p0 = prog_cnt; seen = 0;
    app_mode = app; crc_err = crc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4000 && !seen; k++) begin
      @(negedge clk);
      if (run_done) seen = 1;
    end
    chk("R12 run completes", 32'(seen), 32'd1);
    @(negedge clk);
    d_boot = boot_cnt - b0; d_prog = prog_cnt - p0;
  endtask

  task automatic t_reset;
    chk("R9 reset reboot", 32'(reboot), 0);
    chk("R8 reset prog_n", 32'(prog_n), 1);
    chk("R11 reset no_image", 32'(no_image), 0);
    chk("R12 reset fl_req", 32'(fl_req), 0);
    chk("R12 reset busy", 32'(busy), 0);
  endtask

  task automatic t_fresh_and_retries;
    fill_hist(8'hFF);
    set_hdr(0, 16'h00FF, 16'd5); set_hdr(1, 16'h00FF, 16'd9); set_hdr(2, 16'hFFFF, 16'hFFFF);
    run(0, 3'b000);
    chk("R2 newest picked", boot_addr_seen, 32'(B2));
    chk("R3 first code", 32'(hist[0]), 32'h2E);
    chk("R9 recorded before reboot", 32'(snap[0]), 32'h2E);
    chk("R9 one pulse", 32'(d_boot), 1);
    chk("R5 next byte untouched", 32'(hist[1]), 32'hFF);
    run(0, 3'b000);
    chk("R3 second code", 32'(hist[0]), 32'h2C);
    run(0, 3'b000);
    chk("R3 third code", 32'(hist[0]), 32'h28);
    chk("R3 retry same image", boot_addr_seen, 32'(B2));
    run(0, 3'b000);
    chk("R4 old byte cleared", 32'(hist[0]), 32'h00);
    chk("R4 next candidate", 32'(hist[1]), 32'h1E);
    chk("R4 header invalidated", {hdr[1][0], hdr[1][1]}, 32'h0000);
    chk("R4 launch fallback", boot_addr_seen, 32'(B1));
    chk("R8 one prog pulse", 32'(d_prog), 1);
  endtask

  task automatic t_app;
    run(1, 3'b000);
    chk("R6 byte cleared", 32'(hist[1]), 32'h00);
    chk("R6 no reboot", 32'(d_boot), 0);
    chk("R6 header kept", {hdr[0][0], hdr[0][1]}, 32'h00FF);
    chk("R6 no prog", 32'(d_prog), 0);
    run(0, 3'b000);
    chk("R5 FF means no history", 32'(hist[2]), 32'h1E);
  endtask

  task automatic t_states;
    fill_hist(8'hFF);
    set_hdr(0, 16'h0000, 16'hFFFF); set_hdr(1, 16'hFFFF, 16'hFFFF); set_hdr(2, 16'h00FF, 16'd2);
    run(0, 3'b000);
    chk("R1 only valid state", boot_addr_seen, 32'(B3));
    chk("R1 code", 32'(hist[0]), 32'h3E);
  endtask

  task automatic t_tie;
    fill_hist(8'hFF);
    set_hdr(0, 16'h00FF, 16'd7); set_hdr(1, 16'h00FF, 16'd7); set_hdr(2, 16'h00FF, 16'd3);
    run(0, 3'b000);
    chk("R2 tie lower number", boot_addr_seen, 32'(B1));
  endtask

  task automatic t_crc;
    fill_hist(8'hFF);
    set_hdr(0, 16'h00FF, 16'd1); set_hdr(1, 16'h00FF, 16'd9); set_hdr(2, 16'h00FF, 16'd4);
    run(0, 3'b010);
    chk("R10 crc image killed", {hdr[1][0], hdr[1][1]}, 32'h0000);
    chk("R10 next best", boot_addr_seen, 32'(B3));
    chk("R8 crc prog pulse", 32'(d_prog), 1);
  endtask

  task automatic t_none;
    fill_hist(8'hFF);
    set_hdr(0, 16'h0000, 16'd1); set_hdr(1, 16'hFFFF, 16'd9); set_hdr(2, 16'h0000, 16'd4);
    run(0, 3'b000);
    chk("R11 flag", 32'(no_image), 1);
    chk("R11 no reboot", 32'(d_boot), 0);
    chk("R11 history untouched", 32'(hist[0]), 32'hFF);
  endtask

  task automatic t_wrap;
    fill_hist(8'h00);
    poke(0, 8'd255, 8'h38);
    set_hdr(0, 16'h00FF, 16'd1); set_hdr(1, 16'hFFFF, 16'hFFFF); set_hdr(2, 16'h00FF, 16'd9);
    run(0, 3'b000);
    chk("R7 new entry at 0", 32'(hist[0]), 32'h1E);
    chk("R7 page erased", 32'(hist[255]), 32'hFF);
    chk("R7 middle erased", 32'(hist[100]), 32'hFF);
    chk("R4 wrap invalidate", {hdr[2][0], hdr[2][1]}, 32'h0000);
    chk("R11 flag cleared", 32'(no_image), 0);
    fill_hist(8'h00);
    set_hdr(0, 16'hFFFF, 16'hFFFF); set_hdr(1, 16'h00FF, 16'd3); set_hdr(2, 16'h0000, 16'd0);
    run(0, 3'b000);
    chk("R7 full page erased", 32'(hist[0]), 32'h2E);
    chk("R7 rest FF", 32'(hist[1]), 32'hFF);
    chk("R12 request stable", 32'(hold_err), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; app_mode = 1'b0; crc_err = '0;
    ld_en = 1'b0; ld_hdr = 1'b0; ld_idx = '0; ld_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_fresh_and_retries;
    t_app;
    t_states;
    t_tie;
    t_crc;
    t_none;
    t_wrap;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule